// File: doc/BRIEF.md
# SD Card Bus Clock Generator

This block derives the SD card bus clock from the module input clock through two cascaded stages. A power-of-two prescaler (ratio 2 to 256) feeds a linear divisor (ratio 1 to 16). The output frequency is the input frequency divided by the product of the two ratios. Software writes one control word. That word carries the prescaler field, the divisor field, a data timeout value for a neighbouring block, a clock gate bit and an initialization request bit.

The divider fields may only change while the card clock is gated off. After every accepted divider change, a stable flag drops and returns once the new clock has run for two full periods. Software then opens the gate. The initialization request sends a fixed burst of 80 divided clocks to the card before any command. It clears itself when the burst ends, and it runs whether or not the gate bit is set.

Top module: `sd_clkgen`

## Requirements
- R1: After the reset input the prescaler field holds 0x80 and the divisor field 0, so the ratio is 256. The gate bit and the timeout value are 0, and the outputs sd_clk, clk_stable and init_busy are low.
- R2: Control word layout: bits [3:0] hold divisor ratio minus one, bits [11:4] hold prescaler ratio divided by two (one-hot), bits [15:12] the timeout value, bit 16 the gate enable and bit 17 the initialization request. The sd_clk period is prescaler ratio times divisor ratio input cycles.
- R3: A prescaler field with several bits set uses its lowest set bit. A zero prescaler field acts as 0x01 (ratio 2).
- R4: Within one sd_clk period the high phase lasts floor(N/2) input cycles and the low phase the rest, where N is the total ratio.
- R5: The divider fields load only from a write whose gate bit is 0 while the gate is already 0. Any other write leaves the period and clk_stable unchanged.
- R6: clk_stable is low in the cycle after a divider load and rises exactly 2·N input cycles after the load edge (likewise after either reset).
- R7: sd_clk stays low while the gate bit is 0 and no initialization burst is running.
- R8: A write with bit 17 set while idle raises init_busy. The burst starts at the next divided-clock period boundary and gives exactly 80 sd_clk rising edges, with the gate bit 0 or 1. init_busy falls 81·N cycles after a request write that also loads the divider.
- R9: Every write copies bits [15:12] to dto_val, whatever the gate state.
- R10: The software reset input restores every state of R1, including the 2·N settle time of R6.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Module input clock |
| rst_n | input | 1 | Asynchronous-free active-low reset, sampled on clk |
| sw_rst | input | 1 | Synchronous software reset, active high |
| wr_en | input | 1 | Control word write strobe |
| wr_data | input | 18 | Control word (layout in R2) |
| sd_clk | output | 1 | Gated divided clock to the card |
| clk_stable | output | 1 | Divided clock has settled on the current setting |
| init_busy | output | 1 | Initialization burst pending or running |
| dto_val | output | 4 | Data timeout value for the data path |

## Verification
The assertions assume that software respects the gating rule: it changes the divider only while gated and does not issue a second divider load in the middle of an initialization burst. They also assume that the resets are held for at least one clock. The stimulus keeps to this rule because every random configuration is applied as a gate-off write, then a load write, then a wait for clk_stable, and only then an enabling write. Initialization requests are issued only from the idle, gated state, and the prescaler draws are limited to ratios of 32 or less so that each period measurement stays short.

// File: rtl/sdclk_pkg.sv
package sdclk_pkg;

   typedef enum logic [1:0] {
      BST_IDLE  = 2'd0,
      BST_ARMED = 2'd1,
      BST_RUN   = 2'd2
   } burst_state_t;

endpackage

// File: rtl/sdclk_ratio.sv
module sdclk_ratio #(
   parameter int PRE_W = 8,
   parameter int DIV_W = 4,
   localparam int RATIO_W = PRE_W + DIV_W + 1,
   localparam int SH_W = $clog2(PRE_W + 1)
) (
   input  logic [PRE_W-1:0]   pre,
   input  logic [DIV_W-1:0]   dv,
   output logic [RATIO_W-1:0] ratio
);

   logic [PRE_W-1:0] lowest;
   logic [SH_W-1:0]  shift;

   // isolate the lowest set prescaler bit
   for (genvar gi = 0; gi < PRE_W; gi++) begin : g_low
      if (gi == 0) begin : g_first
         assign lowest[gi] = pre[gi];
      end else begin : g_rest
         assign lowest[gi] = pre[gi] & ~(|pre[gi-1:0]);
      end
   end

   always_comb begin
      shift = SH_W'(1);
      for (int i = 0; i < PRE_W; i++) begin
         if (lowest[i]) shift = SH_W'(i + 1);
      end
      ratio = ({{(RATIO_W-DIV_W){1'b0}}, dv} + RATIO_W'(1)) << shift;
   end

endmodule

// File: rtl/sdclk_phase.sv
module sdclk_phase #(
   parameter int RATIO_W = 13,
   parameter int SETTLE_PERIODS = 2,
   localparam int ST_W = $clog2(SETTLE_PERIODS + 1)
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               sw_rst,
   input  logic               restart,
   input  logic [RATIO_W-1:0] ratio,
   output logic               phase,
   output logic               wrap,
   output logic               stable
);

   logic [RATIO_W-1:0] cnt, cnt_n, half, last;
   logic [ST_W-1:0]    settle;

   assign half  = ratio >> 1;
   assign last  = ratio - RATIO_W'(1);
   assign wrap  = !restart && (cnt == last);
   assign cnt_n = (restart || wrap) ? '0 : cnt + RATIO_W'(1);

   always_ff @(posedge clk) begin
      if (!rst_n || sw_rst) begin
         cnt    <= '0;
         phase  <= 1'b1;
         settle <= '0;
         stable <= 1'b0;
      end else begin
         cnt   <= cnt_n;
         phase <= (cnt_n < half) || (cnt_n == '0);
         if (restart) begin
            settle <= '0;
            stable <= 1'b0;
         end else if (wrap && !stable) begin
            if (settle == ST_W'(SETTLE_PERIODS - 1)) stable <= 1'b1;
            else settle <= settle + ST_W'(1);
         end
      end
   end

   initial begin
      assert (SETTLE_PERIODS >= 1) else $error("SETTLE_PERIODS must be at least 1");
      assert (RATIO_W >= 2) else $error("RATIO_W too small");
   end

   // R4: the period counter never leaves the current ratio
   a_r4_cnt_range: assert property (@(posedge clk) disable iff (!rst_n || sw_rst)
      cnt < ratio);

   // R4: a high phase starts only at the period boundary
   a_r4_rise_at_zero: assert property (@(posedge clk) disable iff (!rst_n || sw_rst)
      $rose(phase) |-> (cnt == '0));

   // R6: stable rises only on a completed period
   a_r6_rise_on_wrap: assert property (@(posedge clk) disable iff (!rst_n || sw_rst)
      $rose(stable) |-> $past(wrap));

endmodule

// File: rtl/sdclk_burst.sv
module sdclk_burst
   import sdclk_pkg::*;
#(
   parameter int INIT_CLKS = 80,
   localparam int CW = $clog2(INIT_CLKS)
) (
   input  logic clk,
   input  logic rst_n,
   input  logic sw_rst,
   input  logic start,
   input  logic wrap,
   output logic busy,
   output logic run
);

   burst_state_t   state;
   logic [CW-1:0]  icnt;

   always_ff @(posedge clk) begin
      if (!rst_n || sw_rst) begin
         state <= BST_IDLE;
         icnt  <= '0;
      end else begin
         unique case (state)
            BST_IDLE: if (start) state <= BST_ARMED;
            BST_ARMED: if (wrap) begin
               state <= BST_RUN;
               icnt  <= '0;
            end
            BST_RUN: if (wrap) begin
               if (icnt == CW'(INIT_CLKS - 1)) state <= BST_IDLE;
               else icnt <= icnt + CW'(1);
            end
            default: state <= BST_IDLE;
         endcase
      end
   end

   assign busy = (state != BST_IDLE);
   assign run  = (state == BST_RUN);

   initial begin
      assert (INIT_CLKS >= 2) else $error("INIT_CLKS must be at least 2");
   end

   // R8: the running count stays below the burst length
   a_r8_count_range: assert property (@(posedge clk) disable iff (!rst_n || sw_rst)
      run |-> (icnt < CW'(INIT_CLKS)));

   // R8: the burst ends only on a divided-clock period boundary
   a_r8_end_on_wrap: assert property (@(posedge clk) disable iff (!rst_n || sw_rst)
      ($fell(busy) && !$past(sw_rst)) |-> $past(wrap));

endmodule

// File: rtl/sd_clkgen.sv
module sd_clkgen #(
   parameter int PRE_W = 8,
   parameter int DIV_W = 4,
   parameter int TO_W = 4,
   parameter int INIT_CLKS = 80,
   parameter int SETTLE_PERIODS = 2
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic                         sw_rst,
   input  logic                         wr_en,
   input  logic [PRE_W+DIV_W+TO_W+1:0]  wr_data,
   output logic                         sd_clk,
   output logic                         clk_stable,
   output logic                         init_busy,
   output logic [TO_W-1:0]              dto_val
);

   localparam int PRE_LSB  = DIV_W;
   localparam int TO_LSB   = PRE_LSB + PRE_W;
   localparam int EN_BIT   = TO_LSB + TO_W;
   localparam int INIT_BIT = EN_BIT + 1;
   localparam int RATIO_W  = PRE_W + DIV_W + 1;
   localparam logic [PRE_W-1:0] PRE_RST = PRE_W'(1) << (PRE_W - 1);

   logic [PRE_W-1:0]   pre_q;
   logic [DIV_W-1:0]   div_q;
   logic [TO_W-1:0]    to_q;
   logic               en_q;
   logic               load, start;
   logic [RATIO_W-1:0] ratio;
   logic               phase, wrap, run;

   assign load  = wr_en && !en_q && !wr_data[EN_BIT];
   assign start = wr_en && wr_data[INIT_BIT];

   always_ff @(posedge clk) begin
      if (!rst_n || sw_rst) begin
         pre_q <= PRE_RST;
         div_q <= '0;
         to_q  <= '0;
         en_q  <= 1'b0;
      end else if (wr_en) begin
         en_q <= wr_data[EN_BIT];
         to_q <= wr_data[EN_BIT-1:TO_LSB];
         if (load) begin
            pre_q <= wr_data[TO_LSB-1:PRE_LSB];
            div_q <= wr_data[DIV_W-1:0];
         end
      end
   end

   sdclk_ratio #(.PRE_W(PRE_W), .DIV_W(DIV_W)) u_ratio (
      .pre   (pre_q),
      .dv    (div_q),
      .ratio (ratio)
   );

   sdclk_phase #(.RATIO_W(RATIO_W), .SETTLE_PERIODS(SETTLE_PERIODS)) u_phase (
      .clk     (clk),
      .rst_n   (rst_n),
      .sw_rst  (sw_rst),
      .restart (load),
      .ratio   (ratio),
      .phase   (phase),
      .wrap    (wrap),
      .stable  (clk_stable)
   );

   sdclk_burst #(.INIT_CLKS(INIT_CLKS)) u_burst (
      .clk    (clk),
      .rst_n  (rst_n),
      .sw_rst (sw_rst),
      .start  (start),
      .wrap   (wrap),
      .busy   (init_busy),
      .run    (run)
   );

   assign sd_clk  = phase && (en_q || run);
   assign dto_val = to_q;

   initial begin
      assert (PRE_W >= 2) else $error("PRE_W must be at least 2");
      assert (DIV_W >= 1) else $error("DIV_W must be at least 1");
      assert (TO_W >= 1) else $error("TO_W must be at least 1");
   end

   // R6: a divider load drops the stable flag on the following cycle
   a_r6_stable_drops: assert property (@(posedge clk) disable iff (!rst_n || sw_rst)
      $past(load) |-> !clk_stable);

   // R5: divider fields hold while the gate was open
   a_r5_hold_when_gated_on: assert property (@(posedge clk) disable iff (!rst_n || sw_rst)
      ($past(en_q) && !$past(sw_rst)) |-> ($stable(pre_q) && $stable(div_q)));

   // R7: no card clock without gate or burst
   a_r7_gated_low: assert property (@(posedge clk) disable iff (!rst_n || sw_rst)
      (!en_q && !init_busy) |-> !sd_clk);

endmodule

// File: tb/sd_clkgen_test.sv
module sd_clkgen_test;

   localparam int CLK_PERIOD = 10;
   localparam int PRE_W = 8;
   localparam int DIV_W = 4;
   localparam int TO_W = 4;
   localparam int W = PRE_W + DIV_W + TO_W + 2;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         sw_rst = 1'b0;
   logic         wr_en = 1'b0;
   logic [W-1:0] wr_data = '0;
   logic         sd_clk, clk_stable, init_busy;
   logic [TO_W-1:0] dto_val;

   int vectors = 0;
   int miscompares = 0;

   sd_clkgen uut (
      .clk        (clk),
      .rst_n      (rst_n),
      .sw_rst     (sw_rst),
      .wr_en      (wr_en),
      .wr_data    (wr_data),
      .sd_clk     (sd_clk),
      .clk_stable (clk_stable),
      .init_busy  (init_busy),
      .dto_val    (dto_val)
   );

   always #(CLK_PERIOD/2) clk = ~clk;

   function automatic int exp_ratio(int pre, int dv);
      int p = 2;
      for (int i = PRE_W - 1; i >= 0; i--) begin
         if (pre[i]) p = 2 << i;
      end
      return p * (dv + 1);
   endfunction

   function automatic logic [W-1:0] word(bit init, bit en, int to, int pre, int dv);
      return {init, en, TO_W'(to), PRE_W'(pre), DIV_W'(dv)};
   endfunction

   task automatic check(string req, string what, int act, int exp);
      vectors++;
      if (act != exp) begin
         miscompares++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   task automatic write_word(logic [W-1:0] w);
      @(negedge clk);
      wr_data = w;
      wr_en = 1'b1;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic wait_stable(output int c);
      c = 0;
      while (!clk_stable && c < 20000) begin
         @(negedge clk);
         c++;
      end
   endtask

   task automatic measure(output int h, output int l);
      int g = 0;
      h = 0;
      l = 0;
      while (sd_clk && g < 10000) begin @(negedge clk); g++; end
      while (!sd_clk && g < 20000) begin @(negedge clk); g++; end
      while (sd_clk && h < 10000) begin @(negedge clk); h++; end
      while (!sd_clk && l < 10000) begin @(negedge clk); l++; end
   endtask

   task automatic quiet_low(string req, int cycles);
      int seen = 0;
      for (int i = 0; i < cycles; i++) begin
         @(negedge clk);
         if (sd_clk) seen++;
      end
      check(req, "sd_clk high samples while gated", seen, 0);
   endtask

   // load a configuration, check settle time, enable, check period shape
   task automatic run_config(string req, int pre, int dv);
      int n, c, h, l;
      n = exp_ratio(pre, dv);
      write_word(word(0, 0, 14, pre, dv));
      check(req, "stable right after load", int'(clk_stable), 0);
      wait_stable(c);
      check(req, "settle cycles", c, 2 * n);
      write_word(word(0, 1, 14, pre, dv));
      measure(h, l);
      check(req, "high phase", h, n / 2);
      check(req, "low phase", l, n - n / 2);
      write_word(word(0, 0, 14, pre, dv));
   endtask

   initial begin
      #(CLK_PERIOD * 150000);
      miscompares++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
   end

   initial begin
      int c, h, l, rises, n, pre, dv, cyc;
      void'($urandom(32'd20240611));

      repeat (3) @(negedge clk);
      check("R1", "sd_clk in reset", int'(sd_clk), 0);
      check("R1", "stable in reset", int'(clk_stable), 0);
      check("R1", "busy in reset", int'(init_busy), 0);
      check("R1", "dto in reset", int'(dto_val), 0);
      rst_n = 1'b1;
      wait_stable(c);
      check("R6", "settle after reset", c, 512);
      quiet_low("R7", 20);

      // gate on: default ratio 256
      write_word(word(0, 1, 0, 3, 7));
      check("R5", "stable after enabling write", int'(clk_stable), 1);
      measure(h, l);
      check("R1", "default high", h, 128);
      check("R1", "default low", l, 128);

      // gate-off write while gated on must not load
      write_word(word(0, 0, 14, 1, 0));
      check("R5", "stable after gate-off write", int'(clk_stable), 1);
      check("R9", "dto follows write", int'(dto_val), 14);
      quiet_low("R7", 300);

      // directed: fastest ratio
      run_config("R2", 8'h01, 0);
      // directed: largest divisor with prescaler 4
      run_config("R2", 8'h02, 15);
      // directed: zero prescaler field
      run_config("R3", 8'h00, 2);
      // directed: several prescaler bits set
      run_config("R3", 8'h6C, 1);

      // writes while gated on are ignored
      write_word(word(0, 0, 14, 8'h01, 0));
      wait_stable(c);
      write_word(word(0, 1, 5, 8'h10, 5));
      check("R9", "dto while gated on", int'(dto_val), 5);
      write_word(word(0, 1, 5, 8'h20, 9));
      check("R5", "stable kept", int'(clk_stable), 1);
      measure(h, l);
      check("R5", "high unchanged", h, 1);
      check("R5", "low unchanged", l, 1);
      write_word(word(0, 0, 14, 8'h01, 0));

      // initialization bursts with the gate off
      for (int k = 0; k < 2; k++) begin
         n = (k == 0) ? 2 : 6;
         write_word(word(1, 0, 14, (k == 0) ? 8'h01 : 8'h00, (k == 0) ? 0 : 2));
         check("R8", "busy after request", int'(init_busy), 1);
         rises = 0;
         cyc = 0;
         begin
            logic prev = sd_clk;
            while (init_busy && cyc < 5000) begin
               @(negedge clk);
               cyc++;
               if (sd_clk && !prev) rises++;
               prev = sd_clk;
            end
         end
         check("R8", "burst rising edges", rises, 80);
         check("R8", "burst duration", cyc, 81 * n);
         quiet_low("R7", 4 * n);
      end

      // burst with gate on also ends by itself
      write_word(word(1, 1, 14, 8'h01, 0));
      cyc = 0;
      while (init_busy && cyc < 5000) begin @(negedge clk); cyc++; end
      check("R8", "busy clears with gate on", int'(init_busy), 0);
      write_word(word(0, 0, 14, 8'h01, 0));

      // software reset
      @(negedge clk);
      sw_rst = 1'b1;
      @(negedge clk);
      sw_rst = 1'b0;
      check("R10", "dto after soft reset", int'(dto_val), 0);
      check("R10", "stable after soft reset", int'(clk_stable), 0);
      check("R10", "busy after soft reset", int'(init_busy), 0);
      wait_stable(c);
      check("R10", "settle after soft reset", c, 512);
      write_word(word(0, 1, 0, 0, 0));
      measure(h, l);
      check("R10", "high after soft reset", h, 128);
      check("R10", "low after soft reset", l, 128);
      write_word(word(0, 0, 0, 0, 0));

      // constrained random configurations
      for (int it = 0; it < 10; it++) begin
         if ($urandom % 3 == 0) pre = int'($urandom % 32);
         else pre = 1 << ($urandom % 5);
         dv = int'($urandom % 16);
         run_config((pre == 0 || (pre & (pre - 1)) != 0) ? "R3" : "R4", pre, dv);
      end

      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
   end

endmodule